// File: doc/BRIEF.md
# Packet Page Allocator and Queues

This block is the buffer manager for a small network controller. It owns a bitmap of fixed-size buffer pages (2048 bytes each, four pages by default) and three short queues of page numbers. The transmit queue holds pages waiting to go out. The completion queue holds pages whose transmission has finished. The receive queue holds pages filled by incoming frames. Software works the block through a byte-wide register port. It issues commands such as allocate, free, enqueue, pop and clear. It writes a packet-number register, acknowledges interrupts and sets an interrupt mask. It reads back the allocation result, the queue heads, the page total and the number of pages in use.

Two streams meet the block. An arriving frame asks for a page on a valid/ready pair. When the frame is accepted, it takes the lowest-numbered free page and that page joins the receive queue. The transmit side offers the head of the transmit queue on a valid/ready pair. Each accepted hand-off either frees the page or appends it to the completion queue. Back-pressure rules are as follows. `rx_ready` falls while no page is free, while an allocation is pending, while the receive queue is full, or during any register write. `tx_valid` falls during any register write. While `tx_ready` is low, `tx_valid` and `tx_page` hold. An allocation that finds no free page stays pending and is granted automatically once a page is released. The interrupt line is the OR of the status bits that the mask enables.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset, status reads 0x04, mask reads 0x00, the allocation result reads 0x00, pages in use reads 0, and both queue-head reads return the empty code 0x80.
- R2: An allocate command (write 0x20 to address 0) takes the lowest-numbered free page. The page number becomes the allocation result (read address 0) and status bit 3 (value 0x08) is set.
- R3: An allocate with no free page sets the result to 0x80 and clears status bit 3. It stays pending, and in the first cycle without a register write after a page is freed, it takes the lowest free page, sets the result and sets bit 3.
- R4: Writes to address 0 decode bits 7:5 as a command: 0 nothing, 1 allocate, 2 reset all queues, the bitmap and the pending state (result reads 0), 3 pop receive, 4 pop receive and free that page, 5 free the page in the packet-number register, 6 enqueue that page for transmit, 7 empty the transmit and completion queues. Address 1 writes the packet number, 2 acknowledges and 3 sets the mask. Reads: 0 result, 1 packet number, 2 completion head, 3 receive head, 4 status, 5 mask, 6 page total, 7 pages in use.
- R5: An accepted receive request (`rx_valid` and `rx_ready`) takes the lowest free page, appends it to the receive queue and sets status bit 0. A pop moves the next entry to the head, and leaves bit 0 set if entries remain and cleared if the queue empties.
- R6: `tx_valid` is high when `tx_en` is high, the transmit queue is non-empty and no register write is in progress. `tx_page` is the queue head and holds while `tx_ready` is low. On a hand-off the page is freed if `auto_release` is high, or else it is appended to the completion queue if that queue has room.
- R7: Status bit 2 (0x04) is set in every cycle the transmit queue is empty, and it stays set until acknowledged. Status bit 1 (0x02) is set while the completion queue is non-empty.
- R8: An acknowledge write clears only the status bits in (value AND 0xD6). Writing bit 1 pops one completion-queue entry, and has no effect when that queue is empty.
- R9: `irq` is high exactly when status AND mask is non-zero.
- R10: An enqueue onto a full transmit queue (4 entries) is ignored.
- R11: `pages_used` and read address 7 give the number of allocated pages. Read address 6 gives the page total (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_valid | input | 1 | Incoming frame requests a page |
| rx_ready | output | 1 | Page can be granted this cycle |
| tx_en | input | 1 | Transmit enable |
| auto_release | input | 1 | Free pages on hand-off instead of queuing completion |
| tx_valid | output | 1 | Transmit-queue head offered |
| tx_ready | input | 1 | Transmitter takes the offered page |
| tx_page | output | 2 | Offered page number |
| pages_used | output | 3 | Count of allocated pages |
| irq | output | 1 | Interrupt request |

## Verification
A bitmap bit that is wrong shows up on the next allocation or receive grant, as an unexpected page number or a wrong `pages_used` value one cycle after the command. A queue count or entry that is wrong shows up at the next read of a head or at the next transmit hand-off, as a missing, extra or reordered page. A status bit that is not set again correctly shows up as a wrong status read, or as a wrong `irq` level one cycle after the event, which makes sticky and acknowledge corner cases visible at once.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;
  typedef enum logic [2:0] {
    CMD_NOP         = 3'd0,
    CMD_ALLOC       = 3'd1,
    CMD_RESET       = 3'd2,
    CMD_RX_POP      = 3'd3,
    CMD_RX_POP_FREE = 3'd4,
    CMD_FREE        = 3'd5,
    CMD_TX_PUSH     = 3'd6,
    CMD_TX_CLR      = 3'd7
  } mmu_cmd_e;

  // write addresses
  localparam logic [2:0] WA_CMD  = 3'd0;
  localparam logic [2:0] WA_PNUM = 3'd1;
  localparam logic [2:0] WA_ACK  = 3'd2;
  localparam logic [2:0] WA_MASK = 3'd3;

  // read addresses
  localparam logic [2:0] RA_RES   = 3'd0;
  localparam logic [2:0] RA_PNUM  = 3'd1;
  localparam logic [2:0] RA_DONE  = 3'd2;
  localparam logic [2:0] RA_RX    = 3'd3;
  localparam logic [2:0] RA_STAT  = 3'd4;
  localparam logic [2:0] RA_MASK  = 3'd5;
  localparam logic [2:0] RA_TOTAL = 3'd6;
  localparam logic [2:0] RA_USED  = 3'd7;

  // status bit positions
  localparam int IB_RX    = 0;
  localparam int IB_TXD   = 1;
  localparam int IB_TXE   = 2;
  localparam int IB_ALLOC = 3;

  localparam logic [7:0] EMPTY_CODE = 8'h80;
  localparam logic [7:0] ACK_MASK   = 8'hD6;
  localparam logic [7:0] STAT_RESET = 8'h04;
endpackage

// File: rtl/pmmu_bitmap.sv
module pmmu_bitmap #(
  parameter int PAGES = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          alloc,
  input  logic          free_en,
  input  logic [PW-1:0] free_idx,
  output logic          any_free,
  output logic [PW-1:0] low_idx,
  output logic [CW-1:0] used_cnt
);
  logic [PAGES-1:0] bm;

  always_comb begin
    logic found;
    found   = 1'b0;
    low_idx = '0;
    for (int i = 0; i < PAGES; i++) begin
      if (!bm[i] && !found) begin
        low_idx = PW'(i);
        found   = 1'b1;
      end
    end
  end

  assign any_free = ~&bm;

  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < PAGES; i++) used_cnt = used_cnt + CW'(bm[i]);
  end

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                       bm[g] <= 1'b0;
      else if (alloc && low_idx == PW'(g))     bm[g] <= 1'b1;
      else if (free_en && free_idx == PW'(g))  bm[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pmmu_queue.sv
module pmmu_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [W-1:0]  mem [DEPTH];
  logic          pop_eff, push_eff;
  logic [CW-1:0] wr_slot;

  assign pop_eff  = pop && (cnt != '0);
  assign push_eff = push && ((cnt != CW'(DEPTH)) || pop_eff);
  assign wr_slot  = cnt - CW'(pop_eff);
  assign cnt_nxt  = clr ? '0 : (cnt + CW'(push_eff) - CW'(pop_eff));
  assign head     = mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] behind;
    if (g == DEPTH - 1) begin : g_last
      assign behind = mem[g];
    end else begin : g_mid
      assign behind = mem[g+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (push_eff && wr_slot == CW'(g))  mem[g] <= din;
      else if (pop_eff)                        mem[g] <= behind;
    end
  end
endmodule

// File: rtl/pmmu_irq.sv
module pmmu_irq
  import pmmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_en,
  input  logic [7:0] ack_val,
  input  logic       mask_we,
  input  logic [7:0] mask_val,
  input  logic       alloc_clr,
  input  logic       alloc_set,
  input  logic       rx_set,
  input  logic       rx_clr,
  input  logic       txq_empty_nxt,
  input  logic       done_busy_nxt,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);
  logic [7:0] st_nxt;

  always_comb begin
    st_nxt = status & ~(ack_en ? (ack_val & ACK_MASK) : 8'h00);
    if (alloc_clr)     st_nxt[IB_ALLOC] = 1'b0;
    if (alloc_set)     st_nxt[IB_ALLOC] = 1'b1;
    if (rx_clr)        st_nxt[IB_RX]    = 1'b0;
    if (rx_set)        st_nxt[IB_RX]    = 1'b1;
    if (txq_empty_nxt) st_nxt[IB_TXE]   = 1'b1;
    if (done_busy_nxt) st_nxt[IB_TXD]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= STAT_RESET;
      mask   <= 8'h00;
    end else begin
      status <= st_nxt;
      if (mask_we) mask <= mask_val;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import pmmu_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CW   = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic          tx_en,
  input  logic          auto_release,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [PW-1:0] tx_page,
  output logic [CW-1:0] pages_used,
  output logic          irq
);
  mmu_cmd_e      cmd;
  logic          wr_cmd;
  logic          is_alloc, is_reset, is_rxpop, is_rxpf, is_free, is_push, is_txclr;
  logic [PW-1:0] pnum;
  logic [7:0]    alloc_res;
  logic          pending;
  logic          any_free;
  logic [PW-1:0] low_idx;
  logic          alloc_cmd_ok, alloc_pend_ok, rx_acc, tx_fire, bm_alloc;
  logic          free_en;
  logic [PW-1:0] free_idx;
  logic [PW-1:0] txq_head, doneq_head, rxq_head;
  logic [CW-1:0] txq_cnt, doneq_cnt, rxq_cnt;
  logic [CW-1:0] txq_nxt, doneq_nxt, rxq_nxt;
  logic          rx_pop, done_pop;
  logic [7:0]    int_status, int_mask;

  assign cmd       = mmu_cmd_e'(reg_wdata[7:5]);
  assign wr_cmd    = reg_wr && (reg_addr == WA_CMD);
  assign is_alloc  = wr_cmd && (cmd == CMD_ALLOC);
  assign is_reset  = wr_cmd && (cmd == CMD_RESET);
  assign is_rxpop  = wr_cmd && (cmd == CMD_RX_POP);
  assign is_rxpf   = wr_cmd && (cmd == CMD_RX_POP_FREE);
  assign is_free   = wr_cmd && (cmd == CMD_FREE);
  assign is_push   = wr_cmd && (cmd == CMD_TX_PUSH);
  assign is_txclr  = wr_cmd && (cmd == CMD_TX_CLR);

  // grant sources are mutually exclusive: command, pending retry, receive
  assign alloc_cmd_ok  = is_alloc && any_free;
  assign alloc_pend_ok = pending && !reg_wr && any_free;
  assign rx_ready      = any_free && !reg_wr && !pending && (rxq_cnt != CW'(PAGES));
  assign rx_acc        = rx_valid && rx_ready;
  assign bm_alloc      = alloc_cmd_ok || alloc_pend_ok || rx_acc;

  assign tx_valid = tx_en && (txq_cnt != '0) && !reg_wr;
  assign tx_page  = txq_head;
  assign tx_fire  = tx_valid && tx_ready;

  assign rx_pop   = is_rxpop || is_rxpf;
  assign done_pop = reg_wr && (reg_addr == WA_ACK) && reg_wdata[IB_TXD];

  always_comb begin
    free_en  = 1'b0;
    free_idx = pnum;
    if (is_free) begin
      free_en = 1'b1;
    end else if (is_rxpf && (rxq_cnt != '0)) begin
      free_en  = 1'b1;
      free_idx = rxq_head;
    end else if (tx_fire && auto_release) begin
      free_en  = 1'b1;
      free_idx = txq_head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnum      <= '0;
      alloc_res <= 8'h00;
      pending   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == WA_PNUM) pnum <= reg_wdata[PW-1:0];
      if (is_reset) begin
        alloc_res <= 8'h00;
        pending   <= 1'b0;
      end else if (is_alloc) begin
        alloc_res <= any_free ? 8'(low_idx) : EMPTY_CODE;
        pending   <= !any_free;
      end else if (alloc_pend_ok) begin
        alloc_res <= 8'(low_idx);
        pending   <= 1'b0;
      end
    end
  end

  pmmu_bitmap #(.PAGES(PAGES), .PW(PW), .CW(CW)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .clr(is_reset), .alloc(bm_alloc),
    .free_en(free_en), .free_idx(free_idx),
    .any_free(any_free), .low_idx(low_idx), .used_cnt(pages_used)
  );

  pmmu_queue #(.DEPTH(PAGES), .W(PW), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(is_reset || is_txclr),
    .push(is_push), .din(pnum), .pop(tx_fire),
    .head(txq_head), .cnt(txq_cnt), .cnt_nxt(txq_nxt)
  );

  pmmu_queue #(.DEPTH(PAGES), .W(PW), .CW(CW)) u_doneq (
    .clk(clk), .rst_n(rst_n), .clr(is_reset || is_txclr),
    .push(tx_fire && !auto_release), .din(txq_head), .pop(done_pop),
    .head(doneq_head), .cnt(doneq_cnt), .cnt_nxt(doneq_nxt)
  );

  pmmu_queue #(.DEPTH(PAGES), .W(PW), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(is_reset),
    .push(rx_acc), .din(low_idx), .pop(rx_pop),
    .head(rxq_head), .cnt(rxq_cnt), .cnt_nxt(rxq_nxt)
  );

  pmmu_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ack_en(reg_wr && reg_addr == WA_ACK), .ack_val(reg_wdata),
    .mask_we(reg_wr && reg_addr == WA_MASK), .mask_val(reg_wdata),
    .alloc_clr(is_alloc), .alloc_set(alloc_cmd_ok || alloc_pend_ok),
    .rx_set(rx_acc || (rx_pop && rxq_nxt != '0)),
    .rx_clr(rx_pop && rxq_nxt == '0),
    .txq_empty_nxt(txq_nxt == '0), .done_busy_nxt(doneq_nxt != '0),
    .status(int_status), .mask(int_mask), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      RA_RES:   reg_rdata = alloc_res;
      RA_PNUM:  reg_rdata = 8'(pnum);
      RA_DONE:  reg_rdata = (doneq_cnt == '0) ? EMPTY_CODE : 8'(doneq_head);
      RA_RX:    reg_rdata = (rxq_cnt == '0) ? EMPTY_CODE : 8'(rxq_head);
      RA_STAT:  reg_rdata = int_status;
      RA_MASK:  reg_rdata = int_mask;
      RA_TOTAL: reg_rdata = 8'(PAGES);
      default:  reg_rdata = 8'(pages_used);
    endcase
  end
endmodule

// File: rtl/pmmu_chk.sv
module pmmu_chk #(
  parameter int PAGES = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          tx_en,
  input logic          tx_ready,
  input logic          tx_valid,
  input logic [PW-1:0] tx_page,
  input logic          rx_ready,
  input logic [CW-1:0] pages_used,
  input logic          irq,
  input logic [7:0]    int_status,
  input logic [7:0]    int_mask,
  input logic [CW-1:0] txq_cnt,
  input logic [7:0]    alloc_res
);
  // R5
  rx_grant_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (pages_used < CW'(PAGES)));

  // R6
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_en && !reg_wr));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_en || reg_wr || (tx_valid && $stable(tx_page))));

  // R7
  tx_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_cnt == '0) |-> int_status[2]);

  // R3
  alloc_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[7:5] == 3'd1 && pages_used == CW'(PAGES))
      |=> (alloc_res == 8'h80 && !int_status[3]));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask == 8'h00) |-> !irq);

  // R11
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pages_used <= CW'(PAGES));
endmodule

bind pkt_page_mmu pmmu_chk #(.PAGES(PAGES), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_en(tx_en), .tx_ready(tx_ready),
  .tx_valid(tx_valid), .tx_page(tx_page), .rx_ready(rx_ready),
  .pages_used(pages_used), .irq(irq), .int_status(int_status),
  .int_mask(int_mask), .txq_cnt(txq_cnt), .alloc_res(alloc_res)
);

// File: tb/sim_pkt_page_mmu.sv
module sim_pkt_page_mmu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic       tx_en = 1'b0;
  logic       auto_release = 1'b0;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [1:0] tx_page;
  logic [2:0] pages_used;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pkt_page_mmu #(.PAGES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_en(tx_en), .auto_release(auto_release),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_page(tx_page),
    .pages_used(pages_used), .irq(irq)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd4, 8'h00, 8'h04, 4'd1},   // R1 status
    '{1'b0, 3'd5, 8'h00, 8'h00, 4'd1},   // R1 mask
    '{1'b0, 3'd7, 8'h00, 8'h00, 4'd1},   // R1 used
    '{1'b0, 3'd6, 8'h00, 8'h04, 4'd11},  // R11 total
    '{1'b0, 3'd2, 8'h00, 8'h80, 4'd1},   // R1 completion head
    '{1'b0, 3'd3, 8'h00, 8'h80, 4'd1},   // R1 receive head
    '{1'b0, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 result
    '{1'b1, 3'd0, 8'h20, 8'h00, 4'd2},   // R2 allocate
    '{1'b0, 3'd0, 8'h00, 8'h00, 4'd2},
    '{1'b0, 3'd4, 8'h00, 8'h0C, 4'd2},
    '{1'b1, 3'd0, 8'h20, 8'h00, 4'd2},
    '{1'b0, 3'd0, 8'h00, 8'h01, 4'd2},
    '{1'b1, 3'd0, 8'h20, 8'h00, 4'd2},
    '{1'b0, 3'd0, 8'h00, 8'h02, 4'd2},
    '{1'b1, 3'd0, 8'h20, 8'h00, 4'd2},
    '{1'b0, 3'd0, 8'h00, 8'h03, 4'd2},
    '{1'b0, 3'd7, 8'h00, 8'h04, 4'd11},  // R11
    '{1'b1, 3'd0, 8'h20, 8'h00, 4'd3},   // R3 allocate when full
    '{1'b0, 3'd0, 8'h00, 8'h80, 4'd3},
    '{1'b0, 3'd4, 8'h00, 8'h04, 4'd3},
    '{1'b1, 3'd1, 8'h01, 8'h00, 4'd4},   // R4 packet number
    '{1'b0, 3'd1, 8'h00, 8'h01, 4'd4},
    '{1'b1, 3'd0, 8'hA0, 8'h00, 4'd4},   // free page 1 -> pending grant
    '{1'b0, 3'd0, 8'h00, 8'h01, 4'd3},
    '{1'b0, 3'd4, 8'h00, 8'h0C, 4'd3},
    '{1'b1, 3'd2, 8'h09, 8'h00, 4'd8},   // R8 bits 3,0 not clearable
    '{1'b0, 3'd4, 8'h00, 8'h0C, 4'd8},
    '{1'b1, 3'd2, 8'h04, 8'h00, 4'd7},   // R7 reasserted while empty
    '{1'b0, 3'd4, 8'h00, 8'h0C, 4'd7},
    '{1'b1, 3'd1, 8'h02, 8'h00, 4'd4},
    '{1'b1, 3'd0, 8'hC0, 8'h00, 4'd4},   // enqueue page 2
    '{1'b1, 3'd2, 8'h04, 8'h00, 4'd7}    // R7 ack sticks once non-empty
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic rx_one(input int exp_ready, input string tag);
    @(negedge clk);
    rx_valid = 1'b1;
    #2;
    check(tag, int'(rx_ready), exp_ready);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
      else rd(TBL[i].addr, int'(TBL[i].exp), $sformatf("R%0d vec%0d", TBL[i].req, i));
    end
    rd(3'd4, 8'h08, "R7 cleared after ack with queue busy");

    // R9 interrupt line
    wr(3'd3, 8'h08);
    #2 check("R9 irq on alloc bit", int'(irq), 1);
    wr(3'd3, 8'h04);
    #2 check("R9 irq off, masked bit clear", int'(irq), 0);
    wr(3'd3, 8'h00);

    // R6 hand-off with back-pressure
    @(negedge clk);
    tx_en = 1'b1; tx_ready = 1'b0;
    #2 check("R6 tx_valid offered", int'(tx_valid), 1);
    check("R6 tx_page", int'(tx_page), 2);
    @(negedge clk);
    #2 check("R6 held under back-pressure", int'(tx_valid), 1);
    check("R6 page stable", int'(tx_page), 2);
    tx_ready = 1'b1;
    @(negedge clk);
    #2 check("R6 queue drained", int'(tx_valid), 0);
    tx_en = 1'b0; tx_ready = 1'b0;
    rd(3'd4, 8'h0E, "R7 empty and completion bits");
    rd(3'd2, 8'h02, "R6 completion head");
    rd(3'd7, 4, "R11 no release without auto");
    wr(3'd2, 8'h02);
    rd(3'd4, 8'h0C, "R8 ack pops completion");
    rd(3'd2, 8'h80, "R8 completion empty");
    wr(3'd2, 8'h02);
    rd(3'd2, 8'h80, "R8 pop of empty completion");
    rd(3'd4, 8'h0C, "R8 status unchanged");

    // R6 auto-release
    auto_release = 1'b1;
    wr(3'd1, 8'h03);
    wr(3'd0, 8'hC0);
    @(negedge clk);
    tx_en = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    tx_en = 1'b0; tx_ready = 1'b0; auto_release = 1'b0;
    rd(3'd7, 3, "R6 auto-release frees page");
    rd(3'd2, 8'h80, "R6 no completion entry");

    // R5 receive path
    rx_one(1, "R5 rx_ready with free page");
    rd(3'd3, 8'h03, "R5 lowest free page");
    rd(3'd4, 8'h0D, "R5 receive bit");
    @(negedge clk);
    #2 check("R5 rx_ready low when full", int'(rx_ready), 0);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hA0);
    rx_one(1, "R5 second request");
    rd(3'd3, 8'h03, "R5 order kept");
    wr(3'd0, 8'h60);
    rd(3'd3, 8'h00, "R5 pop shifts");
    rd(3'd4, 8'h0D, "R5 bit stays with entries left");
    wr(3'd0, 8'h80);
    rd(3'd3, 8'h80, "R5 queue empty");
    rd(3'd4, 8'h0C, "R5 bit cleared");
    rd(3'd7, 3, "R11 pop-free released one page");

    // R10 full transmit queue
    wr(3'd1, 8'h01);
    for (int k = 0; k < 5; k++) wr(3'd0, 8'hC0);
    n = 0;
    @(negedge clk);
    tx_en = 1'b1; tx_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #2 if (tx_valid) n++;
      @(negedge clk);
    end
    tx_en = 1'b0; tx_ready = 1'b0;
    check("R10 fifth enqueue ignored", n, 4);
    for (int k = 0; k < 3; k++) wr(3'd2, 8'h02);
    rd(3'd2, 8'h01, "R8 one completion left");
    wr(3'd2, 8'h02);
    rd(3'd2, 8'h80, "R8 completion drained");
    rd(3'd4, 8'h0C, "R7 completion bit clear");

    // R4 clear transmit queue
    wr(3'd0, 8'hC0);
    wr(3'd0, 8'hC0);
    wr(3'd0, 8'hE0);
    @(negedge clk);
    tx_en = 1'b1;
    #2 check("R4 clear empties transmit queue", int'(tx_valid), 0);
    tx_en = 1'b0;

    // R9 irq with mask on empty bit
    wr(3'd3, 8'h04);
    #2 check("R9 irq on empty bit", int'(irq), 1);
    wr(3'd3, 8'h00);

    // R4 MMU reset
    wr(3'd0, 8'h40);
    rd(3'd7, 0, "R4 reset frees all");
    rd(3'd0, 8'h00, "R4 reset result");
    rd(3'd3, 8'h80, "R4 reset receive queue");
    wr(3'd0, 8'h20);
    rd(3'd0, 8'h00, "R2 lowest after reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule